// File: doc/BRIEF.md
# Temperature sensor register slave

This block is the register side of a digital temperature sensor that sits behind a byte-oriented serial bus. A bus front end, outside this block, turns line activity into single-cycle event pulses: transaction start, byte written by the host, byte read by the host, and transaction stop. The block keeps a pointer that chooses one of four registers: the live temperature, a configuration byte, a hysteresis threshold and an over-temperature threshold. The three temperature-format registers are 16 bits wide and move over the bus as two bytes, most significant first.

The temperature arrives on a parallel input as a 9-bit two's-complement count of half degrees and is shown left-justified in 16 bits. A comparator drives an over-temperature flag with hysteresis: it rises when the temperature reaches the upper threshold and falls only once the temperature drops under the lower one.

Top module: `tsense_regs`

## Requirements
- R1: A start event returns the byte sequence to its initial position, and the first byte written after a start loads the pointer instead of any register.
- R2: Pointer bits [1:0] choose the register: 0 temperature, 1 configuration, 2 hysteresis threshold, 3 over-temperature threshold; pointer bits [7:2] have no effect.
- R3: For the three 16-bit registers the first data byte of a transaction is the high byte [15:8] and the second is the low byte [7:0]; a read with no pointer write since the start reuses the held pointer and begins at the high byte.
- R4: The byte position saturates at the second place, so every further data byte in the same transaction addresses the low byte again.
- R5: Configuration is one byte; every read in a transaction returns it and every data write replaces it whole.
- R6: The temperature register is read-only: data writes to it leave every register unchanged, while the configuration and both thresholds accept writes.
- R7: A 16-bit value is the 9-bit register in bits [15:7] with bits [6:0] reading as zero; a low-byte write keeps only bit 7 of the byte. The temperature low byte returns the sample held when the sequence reached the second position, not a later one.
- R8: The over-temperature output is set when the signed temperature is at or above the over-temperature threshold, cleared when it is below the hysteresis threshold, and otherwise held; it follows the temperature input two clock cycles later.
- R9: After reset the over-temperature threshold reads 0x5000 (80 °C), the hysteresis threshold 0x4B00 (75 °C), configuration 0x00, the pointer 0 and the over-temperature output 0.
- R10: The read data output presents the requested byte in the cycle after the read event and holds it until the next read event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_start | input | 1 | Transaction start event, one cycle |
| ev_write | input | 1 | Host wrote the byte on wr_byte, one cycle |
| ev_read | input | 1 | Host reads a byte, one cycle |
| ev_stop | input | 1 | Transaction stop event, one cycle |
| wr_byte | input | 8 | Byte written by the host |
| temp_in | input | 9 | Measured temperature, two's complement, 0.5 °C steps |
| rd_byte | output | 8 | Byte returned for the last read event |
| over_temp | output | 1 | Over-temperature flag with hysteresis |

## Verification
The bench builds the block with its default parameters: a 9-bit temperature, an 8-bit pointer and the 80 °C and 75 °C threshold reset values. With these, a low-byte write shows that only one bit survives, a pointer with high bits set shows that only two bits decode, and a temperature code with its sign bit set reaches the signed comparison against a positive threshold. The threshold defaults make the reset read-back a distinct pattern per register, and a temperature change between the two byte reads reaches the held low-byte sample.

// File: rtl/tsense_pkg.sv
// Shared types for the temperature sensor register slave.
// Assumes byte-wide bus transfers and a two-bit register select.
package tsense_pkg;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 2;

    // Position within a transaction's byte sequence.
    typedef enum logic [1:0] {
        SEQ_PTR    = 2'd0,   // next written byte is the pointer
        SEQ_FIRST  = 2'd1,   // next data byte is the high byte
        SEQ_SECOND = 2'd2    // next data byte is the low byte (saturating)
    } seq_e;

    localparam logic [SEL_W-1:0] SEL_TEMP = 2'd0;
    localparam logic [SEL_W-1:0] SEL_CFG  = 2'd1;
    localparam logic [SEL_W-1:0] SEL_HYST = 2'd2;
    localparam logic [SEL_W-1:0] SEL_OVER = 2'd3;
endpackage

// File: rtl/tsense_seq.sv
// Byte sequencer: tracks the pointer and the position inside a transaction.
// Assumes event pulses are one cycle wide; start wins over a same-cycle access.
module tsense_seq
    import tsense_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_start,
    input  logic             ev_write,
    input  logic             ev_read,
    input  logic [SEL_W-1:0] wr_sel,
    output logic [SEL_W-1:0] sel,
    output logic             is_hi,
    output logic             data_wr,
    output logic             data_rd,
    output logic             seq_second
);
    seq_e             idx_q;
    logic [SEL_W-1:0] ptr_q;

    // Advance the sequence and load the pointer on the first written byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= SEQ_PTR;
            ptr_q <= '0;
        end else if (ev_start) begin
            idx_q <= SEQ_PTR;
        end else if (ev_write) begin
            if (idx_q == SEQ_PTR) begin
                ptr_q <= wr_sel;
                idx_q <= SEQ_FIRST;
            end else begin
                idx_q <= SEQ_SECOND;
            end
        end else if (ev_read) begin
            idx_q <= SEQ_SECOND;
        end
    end

    // Decode the current position into access strobes.
    always_comb begin
        sel        = ptr_q;
        is_hi      = (idx_q != SEQ_SECOND);
        seq_second = (idx_q == SEQ_SECOND);
        data_wr    = ev_write && !ev_start && (idx_q != SEQ_PTR);
        data_rd    = ev_read && !ev_start;
    end

    // R1: a start always returns the sequence to the pointer position.
    p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> (idx_q == SEQ_PTR));

    // R4: once at the second position, only a start leaves it.
    p_index_saturates_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q == SEQ_SECOND) && !ev_start |=> (idx_q == SEQ_SECOND));

    // R1: the pointer only changes on a pointer-position write.
    p_ptr_only_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_write && (idx_q == SEQ_PTR)) |=> $stable(ptr_q));
endmodule

// File: rtl/tsense_file.sv
// Register file: thresholds, configuration, temperature sample and read mux.
// Assumes BYTE_W < TEMP_W < 2*BYTE_W; registers are held at TEMP_W bits.
module tsense_file
    import tsense_pkg::*;
#(
    parameter int                TEMP_W   = 9,
    parameter logic [15:0]       OVER_RST = 16'h5000,
    parameter logic [15:0]       HYST_RST = 16'h4B00,
    parameter logic [BYTE_W-1:0] CFG_RST  = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_in,
    input  logic [SEL_W-1:0]  sel,
    input  logic              is_hi,
    input  logic              seq_second,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [TEMP_W-1:0] temp_q,
    output logic [TEMP_W-1:0] over_q,
    output logic [TEMP_W-1:0] hyst_q
);
    localparam int LO_BITS = TEMP_W - BYTE_W;
    localparam int PAD_W   = BYTE_W - LO_BITS;

    logic [BYTE_W-1:0] cfg_q;
    logic [LO_BITS-1:0] temp_lo_hold;

    // Sample the parallel temperature input every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) temp_q <= '0;
        else        temp_q <= temp_in;
    end

    // Freeze the temperature low bits while the sequence sits at the low byte.
    always_ff @(posedge clk) begin
        if (!rst_n)          temp_lo_hold <= '0;
        else if (!seq_second) temp_lo_hold <= temp_q[LO_BITS-1:0];
    end

    // Accept host writes into the writable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            over_q <= OVER_RST[15 -: TEMP_W];
            hyst_q <= HYST_RST[15 -: TEMP_W];
            cfg_q  <= CFG_RST;
        end else if (data_wr) begin
            unique case (sel)
                SEL_CFG: cfg_q <= wr_byte;
                SEL_OVER:
                    if (is_hi) over_q[TEMP_W-1 -: BYTE_W] <= wr_byte;
                    else       over_q[LO_BITS-1:0]        <= wr_byte[BYTE_W-1 -: LO_BITS];
                SEL_HYST:
                    if (is_hi) hyst_q[TEMP_W-1 -: BYTE_W] <= wr_byte;
                    else       hyst_q[LO_BITS-1:0]        <= wr_byte[BYTE_W-1 -: LO_BITS];
                default: ;
            endcase
        end
    end

    // Register the byte selected for a host read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_byte <= '0;
        end else if (data_rd) begin
            unique case (sel)
                SEL_CFG:  rd_byte <= cfg_q;
                SEL_TEMP: rd_byte <= is_hi ? temp_q[TEMP_W-1 -: BYTE_W]
                                           : {temp_lo_hold, {PAD_W{1'b0}}};
                SEL_OVER: rd_byte <= is_hi ? over_q[TEMP_W-1 -: BYTE_W]
                                           : {over_q[LO_BITS-1:0], {PAD_W{1'b0}}};
                default:  rd_byte <= is_hi ? hyst_q[TEMP_W-1 -: BYTE_W]
                                           : {hyst_q[LO_BITS-1:0], {PAD_W{1'b0}}};
            endcase
        end
    end

    // R7: a low-byte read of a 16-bit register shows zeros below the value.
    p_low_pad_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd && !is_hi && (sel != SEL_CFG) |=> (rd_byte[PAD_W-1:0] == '0));

    // R10: the read output changes only after a read event.
    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !data_rd |=> $stable(rd_byte));
endmodule

// File: rtl/tsense_cmp.sv
// Over-temperature comparator with hysteresis (comparator mode).
// Assumes all three inputs are two's-complement in the same units.
module tsense_cmp #(
    parameter int TEMP_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_q,
    input  logic [TEMP_W-1:0] over_q,
    input  logic [TEMP_W-1:0] hyst_q,
    output logic              over_temp
);
    logic at_or_above;
    logic below_hyst;

    // Signed comparisons against both thresholds.
    always_comb begin
        at_or_above = ($signed(temp_q) >= $signed(over_q));
        below_hyst  = ($signed(temp_q) <  $signed(hyst_q));
    end

    // Set on reaching the upper threshold, clear under the lower one.
    always_ff @(posedge clk) begin
        if (!rst_n)          over_temp <= 1'b0;
        else if (at_or_above) over_temp <= 1'b1;
        else if (below_hyst)  over_temp <= 1'b0;
    end

    // R8: between the thresholds the flag keeps its value.
    p_hold_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !at_or_above && !below_hyst |=> $stable(over_temp));

    // R8: the flag never rises while the temperature is under the threshold.
    p_no_false_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !at_or_above |=> !$rose(over_temp));
endmodule

// File: rtl/tsense_regs.sv
// Top of the temperature sensor register slave: joins sequencer,
// register file and comparator. Assumes a front end delivers bus events.
module tsense_regs
    import tsense_pkg::*;
#(
    parameter int                TEMP_W   = 9,
    parameter logic [15:0]       OVER_RST = 16'h5000,
    parameter logic [15:0]       HYST_RST = 16'h4B00,
    parameter logic [BYTE_W-1:0] CFG_RST  = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_start,
    input  logic              ev_write,
    input  logic              ev_read,
    input  logic              ev_stop,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic [TEMP_W-1:0] temp_in,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              over_temp
);
    logic [SEL_W-1:0]  sel;
    logic              is_hi, seq_second, data_wr, data_rd;
    logic [TEMP_W-1:0] temp_q, over_q, hyst_q;
    logic              stop_seen;

    // A stop needs no action: the next start resets the sequence.
    always_comb stop_seen = ev_stop;

    tsense_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_start   (ev_start),
        .ev_write   (ev_write),
        .ev_read    (ev_read),
        .wr_sel     (wr_byte[SEL_W-1:0]),
        .sel        (sel),
        .is_hi      (is_hi),
        .data_wr    (data_wr),
        .data_rd    (data_rd),
        .seq_second (seq_second)
    );

    tsense_file #(
        .TEMP_W   (TEMP_W),
        .OVER_RST (OVER_RST),
        .HYST_RST (HYST_RST),
        .CFG_RST  (CFG_RST)
    ) u_file (
        .clk        (clk),
        .rst_n      (rst_n),
        .temp_in    (temp_in),
        .sel        (sel),
        .is_hi      (is_hi),
        .seq_second (seq_second),
        .data_wr    (data_wr),
        .data_rd    (data_rd),
        .wr_byte    (wr_byte),
        .rd_byte    (rd_byte),
        .temp_q     (temp_q),
        .over_q     (over_q),
        .hyst_q     (hyst_q)
    );

    tsense_cmp #(.TEMP_W(TEMP_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .temp_q    (temp_q),
        .over_q    (over_q),
        .hyst_q    (hyst_q),
        .over_temp (over_temp)
    );

    // R6: a data write aimed at temperature leaves both thresholds unchanged.
    p_temp_read_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr && (sel == SEL_TEMP) |=> $stable(over_q) && $stable(hyst_q));

    // R6: a stop alone never alters a threshold.
    p_stop_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen && !ev_write |=> $stable(over_q) && $stable(hyst_q));
endmodule

// File: tb/tsense_regs_tb_top.sv
// Scoreboard bench for tsense_regs: read tasks queue expected bytes,
// a monitor pops and compares each returned byte.
module tsense_regs_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_start = 1'b0, ev_write = 1'b0, ev_read = 1'b0, ev_stop = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic [8:0] temp_in = 9'h000;
    logic [7:0] rd_byte;
    logic       over_temp;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    tsense_regs dut_i (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_write(ev_write),
        .ev_read(ev_read), .ev_stop(ev_stop), .wr_byte(wr_byte),
        .temp_in(temp_in), .rd_byte(rd_byte), .over_temp(over_temp)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        ev_start = 1'b1; @(negedge clk); ev_start = 1'b0; @(negedge clk);
    endtask

    task automatic bus_stop();
        ev_stop = 1'b1; @(negedge clk); ev_stop = 1'b0; @(negedge clk);
    endtask

    task automatic bus_wr(logic [7:0] b);
        wr_byte = b; ev_write = 1'b1; @(negedge clk); ev_write = 1'b0; @(negedge clk);
    endtask

    task automatic bus_rd(string req, logic [7:0] exp);
        exp_q.push_back(exp); tag_q.push_back(req);
        ev_read = 1'b1; @(negedge clk); ev_read = 1'b0; @(negedge clk);
    endtask

    task automatic set_temp(logic [8:0] t);
        temp_in = t; repeat (3) @(negedge clk);
    endtask

    // Monitor: after each read edge, compare the byte against the queue.
    initial begin
        forever begin
            @(posedge clk);
            if (ev_read && rst_n) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R10 actual %02h expected none", rd_byte);
                end else begin
                    check(tag_q.pop_front(), rd_byte, exp_q.pop_front());
                end
            end
        end
    end

    // Watchdog: a hung run ends as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual %0d expected done", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", {7'd0, over_temp}, 8'h00);
        check("R9", rd_byte, 8'h00);

        // R9: reset values of thresholds and configuration.
        bus_start(); bus_wr(8'h03); bus_rd("R9", 8'h50); bus_rd("R9", 8'h00); bus_stop();
        bus_start(); bus_wr(8'h02); bus_rd("R9", 8'h4B); bus_rd("R9", 8'h00); bus_stop();
        bus_start(); bus_wr(8'h01); bus_rd("R9", 8'h00); bus_stop();

        // R3, R4, R7: temperature 25 C then 25.5 C, high byte first, saturating.
        set_temp(9'h032);
        bus_start(); bus_wr(8'h00);
        bus_rd("R3", 8'h19); bus_rd("R7", 8'h00); bus_rd("R4", 8'h00); bus_stop();
        set_temp(9'h033);
        bus_start(); bus_wr(8'h00); bus_rd("R3", 8'h19); bus_rd("R7", 8'h80); bus_stop();

        // R2: upper pointer bits ignored (0xFE selects hysteresis).
        bus_start(); bus_wr(8'hFE); bus_rd("R2", 8'h4B); bus_stop();

        // R4, R7: threshold write, third byte hits the low byte, only bit 7 kept.
        bus_start(); bus_wr(8'h03); bus_wr(8'h40); bus_wr(8'h00); bus_wr(8'hFF); bus_stop();
        bus_start(); bus_wr(8'h03); bus_rd("R4", 8'h40); bus_rd("R7", 8'h80); bus_stop();
        bus_start(); bus_wr(8'h03); bus_wr(8'h40); bus_wr(8'h7F); bus_stop();

        // R3: read with no pointer write reuses pointer 3, starting high.
        bus_start(); bus_rd("R3", 8'h40); bus_rd("R7", 8'h00); bus_stop();

        // R10: output holds between reads.
        repeat (4) @(negedge clk);
        check("R10", rd_byte, 8'h00);

        // R6: writes to temperature are ignored.
        bus_start(); bus_wr(8'h00); bus_wr(8'hAA); bus_wr(8'h55); bus_stop();
        bus_start(); bus_wr(8'h00); bus_rd("R6", 8'h19); bus_rd("R6", 8'h80); bus_stop();
        bus_start(); bus_wr(8'h03); bus_rd("R6", 8'h40); bus_rd("R6", 8'h00); bus_stop();
        bus_start(); bus_wr(8'h01); bus_rd("R6", 8'h00); bus_stop();

        // R5: configuration single byte.
        bus_start(); bus_wr(8'h01); bus_wr(8'h5A); bus_wr(8'hA5); bus_stop();
        bus_start(); bus_wr(8'h01); bus_rd("R5", 8'hA5); bus_rd("R5", 8'hA5); bus_stop();

        // Hysteresis 60 C.
        bus_start(); bus_wr(8'h02); bus_wr(8'h3C); bus_wr(8'h00); bus_stop();
        bus_start(); bus_wr(8'h02); bus_rd("R6", 8'h3C); bus_stop();

        // R8: comparator with hysteresis (over 64 C, hyst 60 C).
        set_temp(9'h033); check("R8", {7'd0, over_temp}, 8'h00);
        set_temp(9'h07F); check("R8", {7'd0, over_temp}, 8'h00);
        set_temp(9'h080); check("R8", {7'd0, over_temp}, 8'h01);
        set_temp(9'h07A); check("R8", {7'd0, over_temp}, 8'h01);
        set_temp(9'h078); check("R8", {7'd0, over_temp}, 8'h01);
        set_temp(9'h077); check("R8", {7'd0, over_temp}, 8'h00);
        set_temp(9'h07F); check("R8", {7'd0, over_temp}, 8'h00);
        set_temp(9'h100); check("R8", {7'd0, over_temp}, 8'h00);

        // R7: low byte keeps the sample from the high-byte read.
        set_temp(9'h033);
        bus_start(); bus_wr(8'h00); bus_rd("R7", 8'h19);
        temp_in = 9'h064; repeat (3) @(negedge clk);
        bus_rd("R7", 8'h80); bus_stop();

        // R1: start mid-sequence returns to pointer position.
        bus_start(); bus_wr(8'h01); bus_start(); bus_wr(8'h00); bus_rd("R1", 8'h32); bus_stop();

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R10 actual %0d expected 0 pending", exp_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule